// File: doc/BRIEF.md
# Banked Timer Control Access Resolver

This block takes one coprocessor-style read or write aimed at a timer control register and decides, in the same cycle, what the access does. A fixed priority of privilege-dependent checks decides between a trap to level 1 or level 2 with a syndrome code, a hypervisor trap with a code, an undefined-instruction outcome, and an access to one of five physical copies of the register. The inputs are the current privilege level, whether levels 1, 2 and 3 run in 32-bit mode, the host-mode flags, the trap-general flag, several access-enable bits, the secure-state select and a secure-second-level feature flag. The five copies are common, non-secure, secure, host non-secure and host secure.

The copies sit in a small register file inside the block. Each copy holds an enable bit and a mask bit. A read-only status bit combines the enable with a per-copy "condition met" input, and each copy drives its own interrupt line. Exception entry is handled elsewhere. The block only reports which action to take.

The resolver is purely combinational. Its verdict passes through a `unique case` on the privilege level, with one priority chain per level. The register file is the only clocked state. Its single transition is "write accepted", which is taken when the verdict is an access and the request is a write.

Top module: `timer_bank_access`

## Requirements
- R1: Only a valid request whose encoding is coprocessor 0b1111, opc1 0b000, CRn 0b1110, CRm 0b0010, opc2 0b001 is resolved. Any other request yields action IDLE (code 0), and no copy changes.
- R2: At level 0, if level 1 runs 64-bit, level-0 host mode is off and the level-0 access enable is 0, the action is TRAP (code 2) with syndrome 0x03. The target is level 2 when level 2 is enabled, runs 64-bit and the trap-general flag is set. Otherwise the target is level 1.
- R3: At level 0, if level 1 runs 32-bit and the level-0 access enable is 0, three outcomes are tried in order. An enabled 64-bit level 2 with trap-general set gives TRAP to level 2 with syndrome 0x03. Otherwise an enabled 32-bit level 2 with trap-general set gives HYPTRAP (code 3, level 2) with syndrome 0x00. Otherwise the action is UNDEF (code 4).
- R4: At levels 0 and 1, four further trap checks apply. An enabled 64-bit level 2 that is not in host mode, with the level-1 counter enable at 0, gives TRAP to level 2 with syndrome 0x03. Level-2 host mode with the host level-1 timer enable at 0 gives the same TRAP, except at level 0 when trap-general is set. At level 0 only, level-0 host mode with the host level-0 enable at 0 gives the same TRAP. An enabled 32-bit level 2 with the counter enable at 0 gives HYPTRAP with syndrome 0x03.
- R5: At level 0 in host mode, with no trap, the access goes to a hypervisor copy. Secure state (select 0) with the secure-second-level feature picks copy 4 (host secure). Non-secure state (select 1) picks copy 3 (host non-secure). Any other case picks copy 0 (common).
- R6: At levels 1 and 2, with no trap, the access goes to copy 1 (non-secure) when level 3 exists and runs 32-bit. Otherwise it goes to copy 0. Level 2 never traps.
- R7: At level 3, the action is always ACCESS (code 1). Select 0 picks copy 2 (secure) and select 1 picks copy 1.
- R8: The checks are evaluated in the stated priority order, and the first match decides. A verdict output is 0 when it does not apply: the level and syndrome when there is no trap, and the copy index when there is no access.
- R9: A trapped, undefined or idle request leaves every copy unchanged, and its read data is zero. Write data is also zero.
- R10: Register format. Bit 0 is the enable bit and bit 1 is the mask bit, and both are writable. Bit 2 is the status bit and is read-only: it reads enable AND condition-met. Bits 31..3 read zero. A write lands at the next clock edge.
- R11: The interrupt line of copy i is high exactly when its enable is 1, its condition-met input is 1 and its mask is 0.
- R12: After reset, every copy has enable 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| cp_num | input | 4 | Coprocessor number of the request |
| opc1 | input | 3 | First opcode field |
| crn | input | 4 | Primary register field |
| crm | input | 4 | Secondary register field |
| opc2 | input | 3 | Second opcode field |
| wdata | input | 32 | Write data |
| cur_el | input | 2 | Current privilege level 0..3 |
| el1_aa32 | input | 1 | Level 1 runs 32-bit |
| el2_aa32 | input | 1 | Level 2 runs 32-bit |
| el3_aa32 | input | 1 | Level 3 runs 32-bit |
| el2_enabled | input | 1 | Level 2 enabled in the current state |
| el3_present | input | 1 | Level 3 implemented |
| el0_host | input | 1 | Level 0 runs in host mode |
| el2_host | input | 1 | Level 2 runs in host mode |
| tge | input | 1 | Trap-general-exceptions flag |
| l0_acc_en | input | 1 | Level-0 access enable held by level 1 |
| l1_ctr_en | input | 1 | Level-1 counter access enable held by level 2 |
| host_l1_tmr_en | input | 1 | Host level-1 timer access enable |
| host_l0_tmr_en | input | 1 | Host level-0 timer access enable |
| ns_sel | input | 1 | Secure-state select, 1 = non-secure |
| sec_l2_impl | input | 1 | Secure second-level feature present |
| cond_met | input | 5 | Per-copy timer condition met |
| act | output | 3 | Action code |
| trap_lvl | output | 2 | Trap target level |
| syndrome | output | 6 | Trap syndrome code |
| bank | output | 3 | Selected copy index |
| rdata | output | 32 | Read data |
| irq | output | 5 | Per-copy interrupt |

## Verification
The assertions hold the following on every cycle:
- Idle requests resolve to IDLE.
- Level 3 always accesses copy 2 or copy 1, depending on the select bit.
- Level 2 never traps.
- Every trap carries a target level and syndrome 0x03.
- Anything other than an accepted write leaves the stored bits unchanged.
- Non-access read data is zero.
- Interrupts stay consistent with the stored enable and mask.

Only the bench's scenarios show the full priority order between competing traps, the choice among the three outcomes on the 32-bit level-1 path, and the mapping from host flags to copies. The bench also shows that a write reaches the copy it was routed to and reads back with the right status.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

    localparam int NUM_BANKS = 5;
    localparam int BANK_W    = 3;
    localparam int SYN_W     = 6;

    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_ACCESS  = 3'd1,
        ACT_TRAP    = 3'd2,
        ACT_HYPTRAP = 3'd3,
        ACT_UNDEF   = 3'd4
    } act_e;

    typedef enum logic [BANK_W-1:0] {
        BK_COMMON   = 3'd0,
        BK_NSEC     = 3'd1,
        BK_SEC      = 3'd2,
        BK_HOST_NS  = 3'd3,
        BK_HOST_SEC = 3'd4
    } bank_e;

    localparam logic [SYN_W-1:0] SYN_TIMER = 6'h03;
    localparam logic [SYN_W-1:0] SYN_ZERO  = 6'h00;

    typedef struct packed {
        logic [1:0] el;
        logic       el1_aa32;
        logic       el2_aa32;
        logic       el3_aa32;
        logic       el2_en;
        logic       el3_have;
        logic       el0_host;
        logic       el2_host;
        logic       tge;
        logic       l0_acc_en;
        logic       l1_ctr_en;
        logic       host_l1_en;
        logic       host_l0_en;
        logic       ns;
        logic       sec_l2;
    } ctx_t;

    typedef struct packed {
        act_e             act;
        logic [1:0]       lvl;
        logic [SYN_W-1:0] syn;
        bank_e            bank;
    } verdict_t;

    function automatic verdict_t v_trap(input logic [1:0] lvl, input logic [SYN_W-1:0] syn);
        verdict_t v;
        v.act  = ACT_TRAP;
        v.lvl  = lvl;
        v.syn  = syn;
        v.bank = BK_COMMON;
        return v;
    endfunction

    function automatic verdict_t v_hyp(input logic [SYN_W-1:0] syn);
        verdict_t v;
        v.act  = ACT_HYPTRAP;
        v.lvl  = 2'd2;
        v.syn  = syn;
        v.bank = BK_COMMON;
        return v;
    endfunction

    function automatic verdict_t v_plain(input act_e a, input bank_e b);
        verdict_t v;
        v.act  = a;
        v.lvl  = 2'd0;
        v.syn  = SYN_ZERO;
        v.bank = b;
        return v;
    endfunction

endpackage

// File: rtl/tbr_enc_match.sv
module tbr_enc_match #(
    parameter logic [3:0] CP_ID   = 4'b1111,
    parameter logic [2:0] OPC1_ID = 3'b000,
    parameter logic [3:0] CRN_ID  = 4'b1110,
    parameter logic [3:0] CRM_ID  = 4'b0010,
    parameter logic [2:0] OPC2_ID = 3'b001
) (
    input  logic       valid,
    input  logic [3:0] cp_num,
    input  logic [2:0] opc1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] opc2,
    output logic       hit
);
    always_comb begin
        hit = valid
           && (cp_num == CP_ID)
           && (opc1   == OPC1_ID)
           && (crn    == CRN_ID)
           && (crm    == CRM_ID)
           && (opc2   == OPC2_ID);
    end
endmodule

// File: rtl/tbr_decide.sv
module tbr_decide
    import timer_bank_pkg::*;
(
    input  logic     hit,
    input  ctx_t     ctx,
    output verdict_t verdict
);
    logic l2_64_nonhost_off;
    logic l2_32_off;
    logic l2_64_tge;
    logic l2_32_tge;

    always_comb begin
        l2_64_nonhost_off = ctx.el2_en && !ctx.el2_aa32 && !ctx.el2_host && !ctx.l1_ctr_en;
        l2_32_off         = ctx.el2_en &&  ctx.el2_aa32 && !ctx.l1_ctr_en;
        l2_64_tge         = ctx.el2_en && !ctx.el2_aa32 && ctx.tge;
        l2_32_tge         = ctx.el2_en &&  ctx.el2_aa32 && ctx.tge;
    end

    always_comb begin
        verdict = v_plain(ACT_IDLE, BK_COMMON);
        if (hit) begin
            unique case (ctx.el)
                2'd0: begin
                    if (!ctx.el1_aa32 && !ctx.el0_host && !ctx.l0_acc_en) begin
                        if (l2_64_tge) verdict = v_trap(2'd2, SYN_TIMER);
                        else           verdict = v_trap(2'd1, SYN_TIMER);
                    end else if (ctx.el1_aa32 && !ctx.l0_acc_en) begin
                        if (l2_64_tge)      verdict = v_trap(2'd2, SYN_TIMER);
                        else if (l2_32_tge) verdict = v_hyp(SYN_ZERO);
                        else                verdict = v_plain(ACT_UNDEF, BK_COMMON);
                    end else if (l2_64_nonhost_off) begin
                        verdict = v_trap(2'd2, SYN_TIMER);
                    end else if (ctx.el2_host && !ctx.tge && !ctx.host_l1_en) begin
                        verdict = v_trap(2'd2, SYN_TIMER);
                    end else if (ctx.el0_host && !ctx.host_l0_en) begin
                        verdict = v_trap(2'd2, SYN_TIMER);
                    end else if (l2_32_off) begin
                        verdict = v_hyp(SYN_TIMER);
                    end else if (ctx.el0_host && !ctx.ns && ctx.sec_l2) begin
                        verdict = v_plain(ACT_ACCESS, BK_HOST_SEC);
                    end else if (ctx.el0_host && ctx.ns) begin
                        verdict = v_plain(ACT_ACCESS, BK_HOST_NS);
                    end else begin
                        verdict = v_plain(ACT_ACCESS, BK_COMMON);
                    end
                end
                2'd1: begin
                    if (l2_64_nonhost_off) begin
                        verdict = v_trap(2'd2, SYN_TIMER);
                    end else if (ctx.el2_host && !ctx.host_l1_en) begin
                        verdict = v_trap(2'd2, SYN_TIMER);
                    end else if (l2_32_off) begin
                        verdict = v_hyp(SYN_TIMER);
                    end else if (ctx.el3_have && ctx.el3_aa32) begin
                        verdict = v_plain(ACT_ACCESS, BK_NSEC);
                    end else begin
                        verdict = v_plain(ACT_ACCESS, BK_COMMON);
                    end
                end
                2'd2: begin
                    if (ctx.el3_have && ctx.el3_aa32) verdict = v_plain(ACT_ACCESS, BK_NSEC);
                    else                              verdict = v_plain(ACT_ACCESS, BK_COMMON);
                end
                2'd3: begin
                    if (ctx.ns) verdict = v_plain(ACT_ACCESS, BK_NSEC);
                    else        verdict = v_plain(ACT_ACCESS, BK_SEC);
                end
            endcase
        end
    end
endmodule

// File: rtl/tbr_bank_file.sv
module tbr_bank_file
    import timer_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NB     = NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NB-1:0]     cond_met,
    output logic [DATA_W-1:0] rd_word,
    output logic [NB-1:0]     ctl_en,
    output logic [NB-1:0]     ctl_mask,
    output logic [NB-1:0]     irq
);
    localparam int PAD_W = DATA_W - 3;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:2];

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic sel_me;
        assign sel_me = we && (sel == BANK_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_en[i]   <= 1'b0;
                ctl_mask[i] <= 1'b0;
            end else if (sel_me) begin
                ctl_en[i]   <= wdata[0];
                ctl_mask[i] <= wdata[1];
            end
        end

        assign irq[i] = ctl_en[i] && cond_met[i] && !ctl_mask[i];
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NB; i++) begin
            if (sel == BANK_W'(i)) begin
                rd_word = {{PAD_W{1'b0}}, ctl_en[i] & cond_met[i], ctl_mask[i], ctl_en[i]};
            end
        end
    end
endmodule

// File: rtl/timer_bank_access.sv
module timer_bank_access
    import timer_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        cp_num,
    input  logic [2:0]        opc1,
    input  logic [3:0]        crn,
    input  logic [3:0]        crm,
    input  logic [2:0]        opc2,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        cur_el,
    input  logic              el1_aa32,
    input  logic              el2_aa32,
    input  logic              el3_aa32,
    input  logic              el2_enabled,
    input  logic              el3_present,
    input  logic              el0_host,
    input  logic              el2_host,
    input  logic              tge,
    input  logic              l0_acc_en,
    input  logic              l1_ctr_en,
    input  logic              host_l1_tmr_en,
    input  logic              host_l0_tmr_en,
    input  logic              ns_sel,
    input  logic              sec_l2_impl,
    input  logic [4:0]        cond_met,
    output logic [2:0]        act,
    output logic [1:0]        trap_lvl,
    output logic [5:0]        syndrome,
    output logic [2:0]        bank,
    output logic [DATA_W-1:0] rdata,
    output logic [4:0]        irq
);
    logic                 enc_hit;
    ctx_t                 ctx;
    verdict_t             verdict;
    logic                 bank_we;
    logic [DATA_W-1:0]    rd_word;
    logic [NUM_BANKS-1:0] ctl_en;
    logic [NUM_BANKS-1:0] ctl_mask;

    tbr_enc_match u_match (
        .valid  (req_valid),
        .cp_num (cp_num),
        .opc1   (opc1),
        .crn    (crn),
        .crm    (crm),
        .opc2   (opc2),
        .hit    (enc_hit)
    );

    always_comb begin
        ctx.el         = cur_el;
        ctx.el1_aa32   = el1_aa32;
        ctx.el2_aa32   = el2_aa32;
        ctx.el3_aa32   = el3_aa32;
        ctx.el2_en     = el2_enabled;
        ctx.el3_have   = el3_present;
        ctx.el0_host   = el0_host;
        ctx.el2_host   = el2_host;
        ctx.tge        = tge;
        ctx.l0_acc_en  = l0_acc_en;
        ctx.l1_ctr_en  = l1_ctr_en;
        ctx.host_l1_en = host_l1_tmr_en;
        ctx.host_l0_en = host_l0_tmr_en;
        ctx.ns         = ns_sel;
        ctx.sec_l2     = sec_l2_impl;
    end

    tbr_decide u_decide (
        .hit     (enc_hit),
        .ctx     (ctx),
        .verdict (verdict)
    );

    assign bank_we = (verdict.act == ACT_ACCESS) && req_write;

    tbr_bank_file #(.DATA_W(DATA_W), .NB(NUM_BANKS)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bank_we),
        .sel      (verdict.bank),
        .wdata    (wdata),
        .cond_met (cond_met),
        .rd_word  (rd_word),
        .ctl_en   (ctl_en),
        .ctl_mask (ctl_mask),
        .irq      (irq)
    );

    always_comb begin
        act      = verdict.act;
        trap_lvl = verdict.lvl;
        syndrome = verdict.syn;
        bank     = verdict.bank;
        rdata    = (verdict.act == ACT_ACCESS && !req_write) ? rd_word : '0;
    end
endmodule

// File: rtl/timer_bank_access_chk.sv
module timer_bank_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        enc_hit,
    input logic [1:0]  cur_el,
    input logic        ns_sel,
    input logic [2:0]  act,
    input logic [1:0]  trap_lvl,
    input logic [5:0]  syndrome,
    input logic [2:0]  bank,
    input logic [31:0] rdata,
    input logic [4:0]  irq,
    input logic [4:0]  ctl_en,
    input logic [4:0]  ctl_mask
);
    // R1
    idle_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && enc_hit) |-> act == 3'd0);

    // R7
    top_level_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_hit && cur_el == 2'd3) |-> (act == 3'd1 && bank == (ns_sel ? 3'd1 : 3'd2)));

    // R6
    level2_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_hit && cur_el == 2'd2) |-> act == 3'd1);

    // R4
    trap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == 3'd2 |-> (trap_lvl != 2'd0 && syndrome == 6'h03));

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act == 3'd1 && req_write) |=> ($stable(ctl_en) && $stable(ctl_mask)));

    // R9
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act != 3'd1 |-> rdata == 32'd0);

    // R10
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[31:3] == 29'd0);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & (~ctl_en | ctl_mask)) == 5'd0);
endmodule

bind timer_bank_access timer_bank_access_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .enc_hit   (enc_hit),
    .cur_el    (cur_el),
    .ns_sel    (ns_sel),
    .act       (act),
    .trap_lvl  (trap_lvl),
    .syndrome  (syndrome),
    .bank      (bank),
    .rdata     (rdata),
    .irq       (irq),
    .ctl_en    (ctl_en),
    .ctl_mask  (ctl_mask)
);

// File: tb/tb_timer_bank_access.sv
`timescale 1ns/1ps
module tb_timer_bank_access;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_write;
    logic [3:0]  cp_num, crn, crm;
    logic [2:0]  opc1, opc2;
    logic [31:0] wdata;
    logic [1:0]  cur_el;
    logic        el1_aa32, el2_aa32, el3_aa32, el2_enabled, el3_present;
    logic        el0_host, el2_host, tge, l0_acc_en, l1_ctr_en;
    logic        host_l1_tmr_en, host_l0_tmr_en, ns_sel, sec_l2_impl;
    logic [4:0]  cond_met;
    logic [2:0]  act, bank;
    logic [1:0]  trap_lvl;
    logic [5:0]  syndrome;
    logic [31:0] rdata;
    logic [4:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [4:0] m_en = '0, m_mask = '0;

    always #2.5 clk = ~clk;

    timer_bank_access dut (.*);

    typedef struct packed { logic [2:0] a; logic [1:0] l; logic [5:0] s; logic [2:0] b; } exp_t;

    function automatic exp_t mk(input logic [2:0] a, input logic [1:0] l, input logic [5:0] s, input logic [2:0] b);
        exp_t e; e.a = a; e.l = l; e.s = s; e.b = b; return e;
    endfunction

    function automatic exp_t ref_verdict();
        bit hit;
        hit = req_valid && cp_num == 4'hF && opc1 == 3'd0 && crn == 4'hE && crm == 4'h2 && opc2 == 3'd1;
        if (!hit) return mk(0, 0, 0, 0);
        case (cur_el)
            2'd3: return mk(1, 0, 0, ns_sel ? 3'd1 : 3'd2);
            2'd2: return mk(1, 0, 0, (el3_present && el3_aa32) ? 3'd1 : 3'd0);
            2'd1: begin
                if (el2_enabled && !el2_aa32 && !el2_host && !l1_ctr_en) return mk(2, 2, 3, 0);
                if (el2_host && !host_l1_tmr_en) return mk(2, 2, 3, 0);
                if (el2_enabled && el2_aa32 && !l1_ctr_en) return mk(3, 2, 3, 0);
                return mk(1, 0, 0, (el3_present && el3_aa32) ? 3'd1 : 3'd0);
            end
            default: begin
                if (!el1_aa32 && !el0_host && !l0_acc_en)
                    return (el2_enabled && !el2_aa32 && tge) ? mk(2, 2, 3, 0) : mk(2, 1, 3, 0);
                if (el1_aa32 && !l0_acc_en) begin
                    if (el2_enabled && !el2_aa32 && tge) return mk(2, 2, 3, 0);
                    if (el2_enabled && el2_aa32 && tge) return mk(3, 2, 0, 0);
                    return mk(4, 0, 0, 0);
                end
                if (el2_enabled && !el2_aa32 && !el2_host && !l1_ctr_en) return mk(2, 2, 3, 0);
                if (el2_host && !tge && !host_l1_tmr_en) return mk(2, 2, 3, 0);
                if (el0_host && !host_l0_tmr_en) return mk(2, 2, 3, 0);
                if (el2_enabled && el2_aa32 && !l1_ctr_en) return mk(3, 2, 3, 0);
                if (el0_host && !ns_sel && sec_l2_impl) return mk(1, 0, 0, 4);
                if (el0_host && ns_sel) return mk(1, 0, 0, 3);
                return mk(1, 0, 0, 0);
            end
        endcase
    endfunction

    task automatic base();
        req_valid = 1; req_write = 0; cp_num = 4'hF; opc1 = 0; crn = 4'hE; crm = 4'h2; opc2 = 3'd1;
        wdata = 0; cur_el = 0; el1_aa32 = 0; el2_aa32 = 0; el3_aa32 = 0; el2_enabled = 0;
        el3_present = 0; el0_host = 0; el2_host = 0; tge = 0; l0_acc_en = 1; l1_ctr_en = 1;
        host_l1_tmr_en = 1; host_l0_tmr_en = 1; ns_sel = 1; sec_l2_impl = 0; cond_met = 0;
    endtask

    // Called just after a negedge; checks, then lets one clock edge pass.
    task automatic step(input string req);
        exp_t e;
        logic [31:0] erd;
        logic [4:0]  eirq;
        #1;
        e = ref_verdict();
        erd = 0;
        if (e.a == 3'd1 && !req_write)
            erd = {29'd0, m_en[e.b] & cond_met[e.b], m_mask[e.b], m_en[e.b]};
        eirq = m_en & cond_met & ~m_mask;
        checks++;
        if (act !== e.a || trap_lvl !== e.l || syndrome !== e.s || bank !== e.b) begin
            fails++;
            $display("FAIL %s verdict act/lvl/syn/bank got %0d/%0d/%0h/%0d exp %0d/%0d/%0h/%0d",
                     req, act, trap_lvl, syndrome, bank, e.a, e.l, e.s, e.b);
        end
        checks++;
        if (rdata !== erd || irq !== eirq) begin
            fails++;
            $display("FAIL %s rdata/irq got %h/%b exp %h/%b", req, rdata, irq, erd, eirq);
        end
        @(posedge clk);
        if (e.a == 3'd1 && req_write) begin
            m_en[e.b]   = wdata[0];
            m_mask[e.b] = wdata[1];
        end
        @(negedge clk);
    endtask

    task automatic rd_bank(input logic [2:0] b, input string req);
        base(); cond_met = 5'h1F;
        case (b)
            3'd0: cur_el = 2;
            3'd1: begin cur_el = 3; ns_sel = 1; end
            3'd2: begin cur_el = 3; ns_sel = 0; end
            3'd3: begin el0_host = 1; ns_sel = 1; end
            default: begin el0_host = 1; ns_sel = 0; sec_l2_impl = 1; end
        endcase
        step(req);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        base();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: all copies zero after reset
        for (int b = 0; b < 5; b++) rd_bank(3'(b), "R12");

        // R1: non-matching encoding and invalid request
        base(); opc2 = 3'd0; req_write = 1; wdata = 32'h3; step("R1");
        base(); req_valid = 0; req_write = 1; wdata = 32'h3; step("R1");
        rd_bank(0, "R1");

        // R2
        base(); el2_enabled = 1; tge = 1; l0_acc_en = 0; step("R2");
        base(); el2_enabled = 1; tge = 0; l0_acc_en = 0; step("R2");
        // R3
        base(); el1_aa32 = 1; l0_acc_en = 0; el2_enabled = 1; tge = 1; step("R3");
        base(); el1_aa32 = 1; l0_acc_en = 0; el2_enabled = 1; el2_aa32 = 1; tge = 1; step("R3");
        base(); el1_aa32 = 1; l0_acc_en = 0; step("R3");
        // R4
        base(); cur_el = 1; el2_enabled = 1; l1_ctr_en = 0; step("R4");
        base(); cur_el = 1; el2_enabled = 1; el2_aa32 = 1; l1_ctr_en = 0; step("R4");
        base(); el2_host = 1; host_l1_tmr_en = 0; step("R4");
        base(); el0_host = 1; host_l0_tmr_en = 0; step("R4");
        // R8: earlier check wins over later ones
        base(); l0_acc_en = 0; el2_enabled = 1; l1_ctr_en = 0; step("R8");
        base(); el2_host = 1; tge = 1; host_l1_tmr_en = 0; step("R8");
        // R5
        base(); el0_host = 1; ns_sel = 0; sec_l2_impl = 1; step("R5");
        base(); el0_host = 1; ns_sel = 1; step("R5");
        base(); el0_host = 1; ns_sel = 0; sec_l2_impl = 0; step("R5");
        // R6
        base(); cur_el = 1; el3_present = 1; el3_aa32 = 1; step("R6");
        base(); cur_el = 2; el3_present = 1; el3_aa32 = 0; step("R6");
        // R7
        base(); cur_el = 3; ns_sel = 0; step("R7");
        base(); cur_el = 3; ns_sel = 1; step("R7");

        // R10: write all ones, read with and without condition
        base(); cur_el = 2; req_write = 1; wdata = 32'hFFFF_FFFF; step("R10");
        base(); cur_el = 2; cond_met = 5'h01; step("R10");
        base(); cur_el = 2; cond_met = 5'h00; step("R10");
        base(); cur_el = 2; req_write = 1; wdata = 32'h2; step("R10");
        base(); cur_el = 2; cond_met = 5'h01; step("R10");
        // R11: enabled unmasked copy raises its line
        base(); cur_el = 3; ns_sel = 0; req_write = 1; wdata = 32'h1; step("R11");
        base(); cur_el = 3; cond_met = 5'h1F; step("R11");
        // R9: trapped write leaves copy 2 intact
        base(); cur_el = 1; el2_enabled = 1; l1_ctr_en = 0; req_write = 1; wdata = 32'h2; step("R9");
        rd_bank(2, "R9");
        base(); el1_aa32 = 1; l0_acc_en = 0; req_write = 1; wdata = 32'h0; step("R9");
        rd_bank(0, "R9");

        // R8: random mix against the reference
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            req_valid = ($urandom % 16) != 0;
            req_write = r[0];
            cp_num = 4'hF; opc1 = 0; crn = 4'hE; crm = 4'h2; opc2 = 3'd1;
            if (($urandom % 10) == 0) crm = 4'($urandom);
            wdata = $urandom;
            cur_el = r[2:1];
            el1_aa32 = r[3]; el2_aa32 = r[4]; el3_aa32 = r[5]; el2_enabled = r[6];
            el3_present = r[7]; el0_host = r[8]; el2_host = r[9]; tge = r[10];
            l0_acc_en = r[11] | r[12]; l1_ctr_en = r[13] | r[14];
            host_l1_tmr_en = r[15] | r[16]; host_l0_tmr_en = r[17] | r[18];
            ns_sel = r[19]; sec_l2_impl = r[20]; cond_met = r[25:21];
            step("R8");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule